// File: doc/BRIEF.md
# Latched Interrupt Priority Arbiter

This block sits between a set of peripheral interrupt request lines and the instruction sequencer of a processor core. Requests are level-sensitive and held by their sources until serviced. The arbiter looks at them only when the core signals that the current instruction has finished, so an instruction is never cut short by an interrupt. A request counts as pending only when its own enable bit is set and the global interrupt mask is clear.

When at least one request qualifies at an instruction boundary, the arbiter picks the lowest-numbered qualifying source and latches its binary number as the vector index. It raises a one-cycle start pulse and sets the global mask. The latched index stays fixed until the core acknowledges service or software clears the mask. Requests of any priority that arrive in the meantime do not replace it. The mask is kept inside the block, with set and clear strobes from the core and its current value driven out.

Top module: `irq_latch_arb`

## Requirements
- R1: A new selection is made only in a cycle where `insn_done_i` is 1. With `insn_done_i` at 0, `irq_start_o` stays 0 whatever the requests are.
- R2: A source qualifies only if its `req_i` bit and its `en_i` bit are both 1 and `mask_o` is 0 in that cycle. When no source qualifies, nothing is latched and `irq_start_o` stays 0.
- R3: Priority is fixed: bit 0 is the highest and bit N_SRC-1 the lowest. `vec_idx_o` is the binary number of the winning bit. It holds that value while `busy_o` is 1 and reads 0 while `busy_o` is 0.
- R4: While `busy_o` is 1, no request replaces the latched index and `irq_start_o` is not raised again, even for a higher-priority source.
- R5: When `svc_ack_i` is 1, `busy_o` is 0 and `vec_idx_o` is 0 on the next cycle. The mask is left unchanged.
- R6: A capture sets `mask_o` to 1 and `busy_o` to 1 on the following cycle. In that same cycle `irq_start_o` is 1, and it lasts exactly one cycle.
- R7: When `mask_clr_i` is 1, the latch is released and `mask_o` goes to 0 on the next cycle, unless `mask_set_i` is also 1, in which case the mask is set. A cycle with `mask_clr_i` or `svc_ack_i` at 1 never captures, and `mask_set_i` alone sets the mask.
- R8: After reset, `mask_o` is 1 and `busy_o`, `irq_start_o` and `vec_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Level-sensitive interrupt requests |
| en_i | input | N_SRC | Per-source enable bits |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| svc_ack_i | input | 1 | Core acknowledges service of the latched source |
| mask_set_i | input | 1 | Set the global mask |
| mask_clr_i | input | 1 | Clear the global mask and release the latch |
| irq_start_o | output | 1 | One-cycle pulse: interrupt processing begins |
| vec_idx_o | output | IDX_W | Latched winning source number |
| busy_o | output | 1 | A selection is latched |
| mask_o | output | 1 | Global interrupt mask |

## Verification
The bench targets four cases. Several requests are enabled at once, and an enable is cleared on the highest requester; a design with the wrong priority order, or one that ignores enables, latches the wrong index. While a selection is held, a higher-priority request is raised at a boundary; a design that re-arbitrates would change `vec_idx_o` or pulse `irq_start_o` again. The bench also covers a mask clear coinciding with a boundary and requests with no boundary strobe, which catch a design that evaluates the mask late or samples outside instruction boundaries. Release by acknowledge is checked to leave the mask set, and release by mask clear to clear it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             mask_i,
  output logic [N_SRC-1:0] act_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_gate
    assign act_o[i] = req_i[i] & en_i[i] & ~mask_i;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = idx_width(N_SRC)
) (
  input  logic [N_SRC-1:0] act_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0]   seen;
  logic [N_SRC-1:0] win;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    // lowest number wins: a bit wins if nothing below it is active
    assign win[i]    = act_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | act_i[i];
  end
  assign any_o = seen[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (win[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = idx_width(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             insn_done_i,
  input  logic             svc_ack_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  output logic             start_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             mask_o
);
  logic capture, release_s;

  assign release_s = svc_ack_i | mask_clr_i;
  // any_i already includes the mask; releases block a same-cycle capture
  assign capture   = insn_done_i & any_i & ~busy_o & ~release_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      idx_o   <= '0;
      start_o <= 1'b0;
      mask_o  <= 1'b1;
    end else begin
      start_o <= capture;
      if (release_s) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else if (capture) begin
        busy_o <= 1'b1;
        idx_o  <= win_idx_i;
      end
      if (capture || mask_set_i) mask_o <= 1'b1;
      else if (mask_clr_i)       mask_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_latch_arb.sv
module irq_latch_arb
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = idx_width(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             insn_done_i,
  input  logic             svc_ack_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  output logic             irq_start_o,
  output logic [IDX_W-1:0] vec_idx_o,
  output logic             busy_o,
  output logic             mask_o
);
  logic [N_SRC-1:0] act;
  logic             any_act;
  logic [IDX_W-1:0] win_idx;

  irq_qualify #(.N_SRC(N_SRC)) u_qual (
    .req_i  (req_i),
    .en_i   (en_i),
    .mask_i (mask_o),
    .act_o  (act)
  );

  irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .act_i (act),
    .any_o (any_act),
    .idx_o (win_idx)
  );

  irq_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .any_i       (any_act),
    .win_idx_i   (win_idx),
    .insn_done_i (insn_done_i),
    .svc_ack_i   (svc_ack_i),
    .mask_set_i  (mask_set_i),
    .mask_clr_i  (mask_clr_i),
    .start_o     (irq_start_o),
    .idx_o       (vec_idx_o),
    .busy_o      (busy_o),
    .mask_o      (mask_o)
  );
endmodule

// File: rtl/irq_latch_arb_chk.sv
module irq_latch_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = idx_width(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] en_i,
  input logic             insn_done_i,
  input logic             svc_ack_i,
  input logic             mask_set_i,
  input logic             mask_clr_i,
  input logic             irq_start_o,
  input logic [IDX_W-1:0] vec_idx_o,
  input logic             busy_o,
  input logic             mask_o
);
  logic [N_SRC-1:0] act_q;
  logic             mask_q, done_q, clr_q, ack_q, busy_q;
  logic [N_SRC-1:0] below;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      mask_q <= 1'b1;
      done_q <= 1'b0;
      clr_q  <= 1'b0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      act_q  <= req_i & en_i;
      mask_q <= mask_o;
      done_q <= insn_done_i;
      clr_q  <= mask_clr_i;
      ack_q  <= svc_ack_i;
      busy_q <= busy_o;
    end
  end

  assign below = (N_SRC'(1) << vec_idx_o) - N_SRC'(1);

  assert_boundary_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |-> done_q);
  assert_unmasked_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |-> (!mask_q && act_q[vec_idx_o]));
  assert_lowest_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |-> ((act_q & below) == '0));
  assert_idle_idx_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (vec_idx_o == '0));
  assert_no_preempt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !svc_ack_i && !mask_clr_i) |=> (busy_o && $stable(vec_idx_o) && !irq_start_o));
  assert_ack_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_ack_i |=> (!busy_o && $stable(mask_o) || mask_set_i && $past(mask_set_i)) );
  assert_start_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |-> (mask_o && busy_o && !busy_q));
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |=> !irq_start_o);
  assert_clr_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> (!mask_o && !busy_o));
  assert_no_capture_on_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_start_o |-> (!clr_q && !ack_q));
endmodule

bind irq_latch_arb irq_latch_arb_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_latch_arb_tb.sv
module irq_latch_arb_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, en = '0;
  logic          done = 1'b0, ack = 1'b0, mset = 1'b0, mclr = 1'b0;
  logic          start, busy, mask;
  logic [IW-1:0] idx;
  int            checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_latch_arb #(.N_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_i(en),
    .insn_done_i(done), .svc_ack_i(ack), .mask_set_i(mset), .mask_clr_i(mclr),
    .irq_start_o(start), .vec_idx_o(idx), .busy_o(busy), .mask_o(mask)
  );

  // {req, en, expect_start, expect_idx}
  localparam logic [19:0] VEC [8] = '{
    {8'h01, 8'hFF, 1'b1, 3'd0},
    {8'h80, 8'hFF, 1'b1, 3'd7},
    {8'hA4, 8'hFF, 1'b1, 3'd2},
    {8'hA4, 8'hFB, 1'b1, 3'd5},
    {8'hFF, 8'h00, 1'b0, 3'd0},
    {8'h00, 8'hFF, 1'b0, 3'd0},
    {8'h60, 8'h40, 1'b1, 3'd6},
    {8'hF0, 8'hF0, 1'b1, 3'd4}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    step(); step();
    // R8 reset state
    chk("R8 mask", int'(mask), 1);
    chk("R8 busy", int'(busy), 0);
    chk("R8 start", int'(start), 0);
    chk("R8 idx", int'(idx), 0);
    rst_n = 1'b1;
    // R2: masked after reset, nothing starts
    req = 8'h10; en = 8'hFF; done = 1'b1; step();
    chk("R2 masked start", int'(start), 0);
    chk("R2 masked busy", int'(busy), 0);
    done = 1'b0; req = '0;

    // table: R2 R3 R6
    foreach (VEC[k]) begin
      mclr = 1'b1; step(); mclr = 1'b0;
      req = VEC[k][19:12]; en = VEC[k][11:4]; done = 1'b1; step();
      chk($sformatf("R3 vec%0d start", k), int'(start), int'(VEC[k][3]));
      chk($sformatf("R3 vec%0d idx", k), int'(idx), int'(VEC[k][2:0]));
      chk($sformatf("R6 vec%0d mask", k), int'(mask), int'(VEC[k][3]));
      done = 1'b0; req = '0; ack = 1'b1; step(); ack = 1'b0;
    end

    // R1: no boundary, no start
    mclr = 1'b1; step(); mclr = 1'b0;
    req = 8'h08; en = 8'hFF;
    for (int c = 0; c < 4; c++) begin
      step();
      chk("R1 no boundary", int'(start | busy), 0);
    end

    // R6 pulse width, R4 hold against higher priority
    done = 1'b1; step();
    chk("R6 start", int'(start), 1);
    chk("R3 idx 3", int'(idx), 3);
    req = 8'h09; mclr = 1'b0; step();
    chk("R6 one pulse", int'(start), 0);
    chk("R4 held idx", int'(idx), 3);
    chk("R4 busy", int'(busy), 1);
    req = 8'h01; step();
    chk("R4 no restart", int'(start), 0);
    chk("R4 idx after higher req", int'(idx), 3);
    done = 1'b0;

    // R5: ack releases, mask kept
    ack = 1'b1; step(); ack = 1'b0;
    chk("R5 busy", int'(busy), 0);
    chk("R5 idx", int'(idx), 0);
    chk("R5 mask kept", int'(mask), 1);

    // R7: clear coinciding with boundary does not capture
    mclr = 1'b1; done = 1'b1; step(); mclr = 1'b0;
    chk("R7 no capture on clear", int'(start), 0);
    chk("R7 mask cleared", int'(mask), 0);
    step();
    chk("R7 capture next boundary", int'(start), 1);
    chk("R3 idx 0", int'(idx), 0);
    done = 1'b0;
    // R7: mask clear releases latch
    mclr = 1'b1; step(); mclr = 1'b0;
    chk("R7 release busy", int'(busy), 0);
    chk("R7 release mask", int'(mask), 0);
    // R7: mask set blocks
    mset = 1'b1; step(); mset = 1'b0;
    chk("R7 set mask", int'(mask), 1);
    done = 1'b1; step(); done = 1'b0;
    chk("R2 set mask blocks", int'(start), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule